// File: doc/BRIEF.md
# Aliased Wide/Narrow Vector Register Bank

This block is a bank of vector registers, each 256 bits wide. The lower 128 bits of every register can also be read and written as a 128-bit register of its own. It is the same storage, not a copy. Two combinational read ports each return either the whole register or only its lower view. One write port carries a merge-mode code, and that code decides what happens to the upper half of the target. The three choices are: keep the upper half, clear it to zero, or overwrite it from the write data.

A separate context port reads and writes only the upper halves. Surrounding logic uses it to save and restore that part of the state without going through the normal ports.

All reads see writes from the same cycle. Every read returns the value that the register will hold after the coming clock edge, with the merge rule already applied. The block has no state machine. Each register is a plain pair of half-width storage slots, and a write decoder picks, per slot and per cycle, whether to load it and from which source. Reset is asynchronous and active low.

Top module: `vreg_alias_bank`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero in both halves, and it reads as zero afterwards until it is written.
- R2: A write with `wr_mode` = 2'b00 (keep-upper) loads bits 127:0 from `wr_data[127:0]` and leaves bits 255:128 of the target unchanged.
- R3: A write with `wr_mode` = 2'b01 (zero-upper) loads bits 127:0 from `wr_data[127:0]` and sets bits 255:128 of the target to zero.
- R4: A write with `wr_mode` = 2'b10 (full) loads all 256 bits of the target from `wr_data`.
- R5: A write with `wr_mode` = 2'b11 (skip) changes no bit of any register.
- R6: A read port with its wide select at 1 returns all 256 bits of the addressed register. With the select at 0, it returns bits 127:0 in `rdN_data[127:0]` and zeros in `rdN_data[255:128]`. The two ports are independent.
- R7: A read (on either port or on the context port) of the register being written in the same cycle returns the post-write value, with the merge rule applied.
- R8: `ctx_rdata` returns bits 255:128 of the register selected by `ctx_idx` at any time.
- R9: A context write (`ctx_we` = 1) loads bits 255:128 of the register `ctx_idx` from `ctx_wdata` and does not change bits 127:0.
- R10: When a context write and a zero-upper or full normal write target the same register in one cycle, the normal write sets the upper half. When the normal write is keep-upper or skip, the context write sets it.
- R11: With `wr_en` = 0 and `ctx_we` = 0, no register changes, whatever the data and mode inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_wide | input | 1 | Read port 0: 1 = full 256 bits, 0 = lower view |
| rd0_data | output | 256 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_wide | input | 1 | Read port 1: 1 = full 256 bits, 0 = lower view |
| rd1_data | output | 256 | Read port 1 data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write register index |
| wr_mode | input | 2 | Merge mode: 00 keep-upper, 01 zero-upper, 10 full, 11 skip |
| wr_data | input | 256 | Normal write data |
| ctx_idx | input | 4 | Context port register index |
| ctx_we | input | 1 | Context port write enable (upper half only) |
| ctx_wdata | input | 128 | Context port write data |
| ctx_rdata | output | 128 | Upper half of the register at `ctx_idx` |

## Verification
The bench builds the bank with its default parameters: sixteen registers and 128-bit halves. At that size a random walk of a few hundred cycles hits every register many times, with all four merge modes. Same-index collisions between the normal write, both read ports and the context port come up often, with no special steering. The full-width halves mean that a mistake in either half's data path, or a swapped half, shows up as a distinct data mismatch.

// File: rtl/vreg_alias_pkg.sv
package vreg_alias_pkg;

    // Merge-mode code carried on the write port; the encoding is visible at the port.
    typedef enum logic [1:0] {
        MRG_KEEP_HI = 2'b00,
        MRG_ZERO_HI = 2'b01,
        MRG_FULL    = 2'b10,
        MRG_SKIP    = 2'b11
    } merge_mode_e;

endpackage

// File: rtl/vreg_wr_decode.sv
module vreg_wr_decode
    import vreg_alias_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int LANE_W   = 128,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  merge_mode_e          wr_mode,
    input  logic [LANE_W-1:0]    wr_hi_data,
    input  logic                 ctx_we,
    input  logic [IDX_W-1:0]     ctx_idx,
    input  logic [LANE_W-1:0]    ctx_wdata,
    output logic [NUM_REGS-1:0]  lo_we,
    output logic [NUM_REGS-1:0]  hi_we,
    output logic [LANE_W-1:0]    hi_d [NUM_REGS]
);

    logic mode_touch_hi;
    logic mode_touch_lo;

    assign mode_touch_lo = (wr_mode != MRG_SKIP);
    assign mode_touch_hi = (wr_mode == MRG_ZERO_HI) || (wr_mode == MRG_FULL);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        logic hit_n;
        logic hit_c;
        logic n_hi;

        assign hit_n = wr_en  && (wr_idx  == IDX_W'(g));
        assign hit_c = ctx_we && (ctx_idx == IDX_W'(g));
        assign n_hi  = hit_n && mode_touch_hi;

        assign lo_we[g] = hit_n && mode_touch_lo;
        assign hi_we[g] = n_hi || hit_c;
        // the normal port has priority on the upper half
        assign hi_d[g]  = n_hi ? ((wr_mode == MRG_FULL) ? wr_hi_data : {LANE_W{1'b0}})
                               : ctx_wdata;
    end

    // R11: without any enable, no slot may be loaded
    always_comb begin
        if (!wr_en && !ctx_we) begin
            assert_idle_no_load_R11: assert ((lo_we == '0) && (hi_we == '0));
        end
    end

endmodule

// File: rtl/vreg_slot.sv
module vreg_slot #(
    parameter int LANE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic [LANE_W-1:0] lo_d,
    input  logic              hi_we,
    input  logic [LANE_W-1:0] hi_d,
    output logic [LANE_W-1:0] lo_q,
    output logic [LANE_W-1:0] hi_q,
    output logic [LANE_W-1:0] lo_nxt,
    output logic [LANE_W-1:0] hi_nxt
);

    assign lo_nxt = lo_we ? lo_d : lo_q;
    assign hi_nxt = hi_we ? hi_d : hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_nxt;
            hi_q <= hi_nxt;
        end
    end

endmodule

// File: rtl/vreg_rd_port.sv
module vreg_rd_port #(
    parameter int NUM_REGS = 16,
    parameter int LANE_W   = 128,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int VEC_W   = 2 * LANE_W
) (
    input  logic [LANE_W-1:0] lo_v [NUM_REGS],
    input  logic [LANE_W-1:0] hi_v [NUM_REGS],
    input  logic [IDX_W-1:0]  idx,
    input  logic              wide,
    output logic [VEC_W-1:0]  data
);

    logic [LANE_W-1:0] lo_sel;
    logic [LANE_W-1:0] hi_sel;

    assign lo_sel = lo_v[idx];
    assign hi_sel = hi_v[idx];
    assign data   = {(wide ? hi_sel : {LANE_W{1'b0}}), lo_sel};

endmodule

// File: rtl/vreg_alias_bank.sv
module vreg_alias_bank
    import vreg_alias_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int LANE_W   = 128,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int VEC_W   = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic              rd0_wide,
    output logic [VEC_W-1:0]  rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic              rd1_wide,
    output logic [VEC_W-1:0]  rd1_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_mode,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  ctx_idx,
    input  logic              ctx_we,
    input  logic [LANE_W-1:0] ctx_wdata,
    output logic [LANE_W-1:0] ctx_rdata
);

    merge_mode_e         mode;
    logic [NUM_REGS-1:0] lo_we;
    logic [NUM_REGS-1:0] hi_we;
    logic [LANE_W-1:0]   hi_d   [NUM_REGS];
    logic [LANE_W-1:0]   lo_q   [NUM_REGS];
    logic [LANE_W-1:0]   hi_q   [NUM_REGS];
    logic [LANE_W-1:0]   lo_nxt [NUM_REGS];
    logic [LANE_W-1:0]   hi_nxt [NUM_REGS];

    assign mode = merge_mode_e'(wr_mode);

    vreg_wr_decode #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) u_dec (
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_mode    (mode),
        .wr_hi_data (wr_data[VEC_W-1:LANE_W]),
        .ctx_we     (ctx_we),
        .ctx_idx    (ctx_idx),
        .ctx_wdata  (ctx_wdata),
        .lo_we      (lo_we),
        .hi_we      (hi_we),
        .hi_d       (hi_d)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        vreg_slot #(.LANE_W(LANE_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .lo_we  (lo_we[g]),
            .lo_d   (wr_data[LANE_W-1:0]),
            .hi_we  (hi_we[g]),
            .hi_d   (hi_d[g]),
            .lo_q   (lo_q[g]),
            .hi_q   (hi_q[g]),
            .lo_nxt (lo_nxt[g]),
            .hi_nxt (hi_nxt[g])
        );
    end

    // read ports look at the post-merge next values (same-cycle forwarding)
    vreg_rd_port #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) u_rd0 (
        .lo_v (lo_nxt), .hi_v (hi_nxt), .idx (rd0_idx), .wide (rd0_wide), .data (rd0_data)
    );

    vreg_rd_port #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) u_rd1 (
        .lo_v (lo_nxt), .hi_v (hi_nxt), .idx (rd1_idx), .wide (rd1_wide), .data (rd1_data)
    );

    assign ctx_rdata = hi_nxt[ctx_idx];

    // ---------------------------------------------------------------- checks
    assert_keep_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MRG_KEEP_HI && !(ctx_we && ctx_idx == wr_idx))
        |=> (hi_q[$past(wr_idx)] == $past(hi_q[wr_idx])));

    assert_zero_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MRG_ZERO_HI)
        |=> (hi_q[$past(wr_idx)] == '0));

    assert_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MRG_FULL)
        |=> ({hi_q[$past(wr_idx)], lo_q[$past(wr_idx)]} == $past(wr_data)));

    assert_skip_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MRG_SKIP)
        |=> (lo_q[$past(wr_idx)] == $past(lo_q[wr_idx])));

    assert_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MRG_FULL && rd0_wide && rd0_idx == wr_idx)
        |-> (rd0_data == wr_data));

    assert_ctx_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_we && !(wr_en && wr_idx == ctx_idx))
        |=> (lo_q[$past(ctx_idx)] == $past(lo_q[ctx_idx])));

endmodule

// File: tb/vreg_alias_bank_test.sv
module vreg_alias_bank_test;

    localparam int NR = 16;
    localparam int LW = 128;
    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rd0_idx = '0, rd1_idx = '0, wr_idx = '0, ctx_idx = '0;
    logic          rd0_wide = 1'b0, rd1_wide = 1'b0, wr_en = 1'b0, ctx_we = 1'b0;
    logic [1:0]    wr_mode = '0;
    logic [VW-1:0] wr_data = '0;
    logic [LW-1:0] ctx_wdata = '0;
    logic [VW-1:0] rd0_data, rd1_data;
    logic [LW-1:0] ctx_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [VW-1:0] mdl [NR];

    // scoreboard queues
    string         q_tag [$];
    logic [VW-1:0] q_e0  [$];
    logic [VW-1:0] q_e1  [$];
    logic [LW-1:0] q_es  [$];

    always #10 clk = ~clk;

    vreg_alias_bank uut (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_wide(rd0_wide), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_wide(rd1_wide), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_data(wr_data),
        .ctx_idx(ctx_idx), .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata)
    );

    function automatic logic [VW-1:0] view(input logic [VW-1:0] v, input logic wide);
        return wide ? v : {{LW{1'b0}}, v[LW-1:0]};
    endfunction

    // driver: apply one cycle of stimulus at the falling edge, predict, push
    task automatic step(input string tag,
                        input logic we, input logic [3:0] wi, input logic [1:0] wm,
                        input logic [VW-1:0] wd,
                        input logic cwe, input logic [3:0] ci, input logic [LW-1:0] cd,
                        input logic [3:0] r0, input logic w0,
                        input logic [3:0] r1, input logic w1);
        logic [VW-1:0] nxt [NR];
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_mode = wm; wr_data = wd;
        ctx_we = cwe; ctx_idx = ci; ctx_wdata = cd;
        rd0_idx = r0; rd0_wide = w0; rd1_idx = r1; rd1_wide = w1;
        for (int i = 0; i < NR; i++) nxt[i] = mdl[i];
        if (cwe) nxt[ci][VW-1:LW] = cd;                        // R9
        if (we) begin
            case (wm)
                2'b00: nxt[wi][LW-1:0] = wd[LW-1:0];                       // R2
                2'b01: nxt[wi] = {{LW{1'b0}}, wd[LW-1:0]};                  // R3
                2'b10: nxt[wi] = wd;                                        // R4
                default: ;                                                  // R5
            endcase
        end
        q_tag.push_back(tag);
        q_e0.push_back(view(nxt[r0], w0));
        q_e1.push_back(view(nxt[r1], w1));
        q_es.push_back(nxt[ci][VW-1:LW]);
        for (int i = 0; i < NR; i++) mdl[i] = nxt[i];
    endtask

    task automatic idle_read(input string tag, input logic [3:0] r0, input logic w0,
                             input logic [3:0] r1, input logic w1, input logic [3:0] ci);
        step(tag, 1'b0, 4'd0, 2'b10, {8{32'hDEAD_BEEF}}, 1'b0, ci, {4{32'hBAD0_BAD0}},
             r0, w0, r1, w1);
    endtask

    // monitor: pop and compare away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_tag.size() > 0) begin
                string t;
                logic [VW-1:0] e0, e1;
                logic [LW-1:0] es;
                t = q_tag.pop_front(); e0 = q_e0.pop_front();
                e1 = q_e1.pop_front(); es = q_es.pop_front();
                checks += 3;
                if (rd0_data !== e0) begin
                    errors++;
                    $display("FAIL %s rd0 actual %h expected %h", t, rd0_data, e0);
                end
                if (rd1_data !== e1) begin
                    errors++;
                    $display("FAIL %s rd1 actual %h expected %h", t, rd1_data, e1);
                end
                if (ctx_rdata !== es) begin
                    errors++;
                    $display("FAIL %s ctx actual %h expected %h", t, ctx_rdata, es);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [VW-1:0] pa, pb;

    initial begin
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        pa = {32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210,
              32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h1111_2222, 32'h3333_4444};
        pb = ~pa;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        idle_read("R1", 4'd0, 1'b1, 4'd15, 1'b1, 4'd9);
        // R4 full write, R7 same-cycle forward on both ports and context port
        step("R7", 1'b1, 4'd3, 2'b10, pa, 1'b0, 4'd3, '0, 4'd3, 1'b1, 4'd3, 1'b0);
        idle_read("R4", 4'd3, 1'b1, 4'd2, 1'b1, 4'd3);
        // R2 keep-upper
        step("R2", 1'b1, 4'd3, 2'b00, pb, 1'b0, 4'd3, '0, 4'd3, 1'b1, 4'd0, 1'b1);
        idle_read("R2", 4'd3, 1'b1, 4'd3, 1'b0, 4'd3);
        // R3 zero-upper
        step("R3", 1'b1, 4'd3, 2'b01, pa, 1'b0, 4'd3, '0, 4'd3, 1'b1, 4'd3, 1'b1);
        idle_read("R3", 4'd3, 1'b1, 4'd1, 1'b1, 4'd3);
        // R5 skip mode on a full register
        step("R5", 1'b1, 4'd4, 2'b10, pb, 1'b0, 4'd4, '0, 4'd4, 1'b1, 4'd4, 1'b0);
        step("R5", 1'b1, 4'd4, 2'b11, pa, 1'b0, 4'd4, '0, 4'd4, 1'b1, 4'd4, 1'b1);
        idle_read("R5", 4'd4, 1'b1, 4'd4, 1'b0, 4'd4);
        // R11 enables low with busy data
        step("R11", 1'b0, 4'd4, 2'b10, pa, 1'b0, 4'd4, pa[LW-1:0], 4'd4, 1'b1, 4'd3, 1'b1);
        // R6 narrow vs wide views on independent ports
        idle_read("R6", 4'd4, 1'b0, 4'd4, 1'b1, 4'd0);
        // R8, R9 context write upper only, then read back
        step("R9", 1'b0, 4'd0, 2'b00, '0, 1'b1, 4'd4, pa[VW-1:LW], 4'd4, 1'b1, 4'd4, 1'b0);
        idle_read("R8", 4'd4, 1'b1, 4'd7, 1'b1, 4'd4);
        // R10 collisions on the upper half
        step("R10", 1'b1, 4'd5, 2'b10, pa, 1'b1, 4'd5, pb[LW-1:0], 4'd5, 1'b1, 4'd5, 1'b1);
        step("R10", 1'b1, 4'd5, 2'b01, pb, 1'b1, 4'd5, pa[LW-1:0], 4'd5, 1'b1, 4'd5, 1'b0);
        step("R10", 1'b1, 4'd5, 2'b00, pa, 1'b1, 4'd5, pb[VW-1:LW], 4'd5, 1'b1, 4'd5, 1'b1);
        step("R10", 1'b1, 4'd5, 2'b11, pa, 1'b1, 4'd5, pa[VW-1:LW], 4'd5, 1'b1, 4'd5, 1'b1);
        idle_read("R10", 4'd5, 1'b1, 4'd5, 1'b0, 4'd5);

        // random mix of modes, indices and context traffic
        for (int n = 0; n < 400; n++) begin
            logic [VW-1:0] d;
            logic [LW-1:0] c;
            for (int k = 0; k < 8; k++) d[k*32 +: 32] = $urandom;
            for (int k = 0; k < 4; k++) c[k*32 +: 32] = $urandom;
            step("R7 random", ($urandom % 4) != 0, 4'($urandom), 2'($urandom), d,
                 ($urandom % 3) == 0, 4'($urandom), c,
                 4'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
        end

        // R1 mid-run reset
        @(negedge clk);
        wr_en = 1'b0; ctx_we = 1'b0;
        rst_n = 1'b0;
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NR; i += 2)
            idle_read("R1", 4'(i), 1'b1, 4'(i + 1), 1'b1, 4'(i));

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule